// File: doc/BRIEF.md
# Flash Command Mode Controller

This block interprets the command writes that arrive on the bus of a NOR-style flash model and keeps track of the mode the device is in. There are seven modes: array read, identification/query read, program busy, program suspended, erase busy, erase suspended, and an error state. On each clock where `wr_en` is high, the controller takes the sector-relative word offset and the command word and decodes them. It then moves between modes according to the rules below. A single `op_done` input stands in for the end of an embedded program or erase.

The mode is presented as a one-hot vector. `read_source` tells the surrounding read path whether reads return array data (0) or identification/query data (1). Command writes are accepted on every cycle, so there is no back-pressure. The storage array, the write-buffer path, the algorithm timing and the query table contents are not part of this block.

Top module: `fcmd_ctrl`

## Requirements
- R1: `mode` is one-hot with bit 0 array read, bit 1 query, bit 2 program busy, bit 3 program suspended, bit 4 erase busy, bit 5 erase suspended, bit 6 error. After reset `mode` is 7'b0000001 and `read_source` is 0.
- R2: In array read, a write whose low byte is 90h or 98h at offset 55h enters query mode one clock later. `read_source` then reads 1. Bits 15..8 of any command word never affect decoding.
- R3: A 90h or 98h write is ignored in every mode other than array read.
- R4: In array read, a 90h or 98h write at an offset other than 55h, or any low byte without a meaning, enters the error state. The error state is left only by F0h.
- R5: F0h returns query, error and array read to array read. It is ignored in the busy and suspended modes.
- R6: In array read, A0h starts program busy and 80h starts erase busy.
- R7: In array read, 33h (blank check) enters erase busy when `cfg_async` is 1. When `cfg_async` is 0 it is rejected and the mode stays array read.
- R8: B0h (suspend) in program busy or erase busy shows the matching suspended mode one clock later. In every other mode it is ignored.
- R9: 30h (resume) moves program suspended to program busy and erase suspended to erase busy. In every other mode it is ignored.
- R10: `op_done` returns program busy or erase busy to array read and is ignored in the other modes. If a suspend write arrives in the same cycle, completion wins.
- R11: Outside array read, any byte not named for the current mode leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one command word per high cycle |
| wr_ofs | input | OFS_W (8) | Word offset within the selected sector |
| wr_data | input | 16 | Command word; only bits 7..0 are decoded |
| cfg_async | input | 1 | Configuration bit: asynchronous read mode selected |
| op_done | input | 1 | Embedded program/erase finished this cycle |
| mode | output | 7 | One-hot current mode |
| read_source | output | 1 | 0 array data, 1 identification/query data |

## Verification
Completion and suspend can fall in the same cycle. This happens when `op_done` is pulsed in a busy mode on the clock that carries a B0h write. The result must be array read, not a suspended mode. The bench provokes this collision from each busy mode, and also pairs `op_done` with resume and with idle cycles in every mode. Each outcome is compared with an arithmetic model of the mode rules. A near-exhaustive sweep covers every mode, all 256 low bytes, a matching and a non-matching offset, and both `cfg_async` values.

// File: rtl/fcmd_pkg.sv
`timescale 1ns/1ps
package fcmd_pkg;

  typedef enum int {
    S_READ  = 0,
    S_QUERY = 1,
    S_PBUSY = 2,
    S_PSUSP = 3,
    S_EBUSY = 4,
    S_ESUSP = 5,
    S_ERROR = 6
  } st_idx_e;

  localparam int N_ST = 7;

  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_QRY_A  = 8'h90;
  localparam logic [7:0] OP_QRY_B  = 8'h98;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_BLANK  = 8'h33;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_RESUME = 8'h30;

  typedef struct packed {
    logic reset;
    logic query_ok;
    logic query_bad;
    logic prog;
    logic erase;
    logic blank;
    logic susp;
    logic resume;
    logic unknown;
  } cmd_t;

  function automatic logic [N_ST-1:0] onehot(st_idx_e i);
    logic [N_ST-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fcmd_decode.sv
`timescale 1ns/1ps
module fcmd_decode
  import fcmd_pkg::*;
#(
  parameter int              OFS_W     = 8,
  parameter logic [OFS_W-1:0] QUERY_OFS = 'h55
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [15:0]      data,
  output cmd_t             cmd
);

  logic [7:0] lo;
  logic       qry_hit;
  logic       ofs_hit;
  logic       unused_hi;

  assign lo        = data[7:0];
  assign unused_hi = ^data[15:8];
  assign qry_hit   = (lo == OP_QRY_A) || (lo == OP_QRY_B);
  assign ofs_hit   = (ofs == QUERY_OFS);

  always_comb begin
    cmd           = '0;
    cmd.reset     = (lo == OP_RESET);
    cmd.query_ok  = qry_hit && ofs_hit;
    cmd.query_bad = qry_hit && !ofs_hit;
    cmd.prog      = (lo == OP_PROG);
    cmd.erase     = (lo == OP_ERASE);
    cmd.blank     = (lo == OP_BLANK);
    cmd.susp      = (lo == OP_SUSP);
    cmd.resume    = (lo == OP_RESUME);
    cmd.unknown   = !(cmd.reset || qry_hit || cmd.prog || cmd.erase ||
                      cmd.blank || cmd.susp || cmd.resume);
  end

endmodule

// File: rtl/fcmd_fsm.sv
`timescale 1ns/1ps
module fcmd_fsm
  import fcmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  cmd_t            cmd,
  input  logic            cfg_async,
  input  logic            op_done,
  output logic [N_ST-1:0] state
);

  logic [N_ST-1:0] nxt;

  always_comb begin
    nxt = state;
    if (state[S_READ]) begin
      if (wr) begin
        if (cmd.reset)          nxt = onehot(S_READ);
        else if (cmd.query_ok)  nxt = onehot(S_QUERY);
        else if (cmd.prog)      nxt = onehot(S_PBUSY);
        else if (cmd.erase)     nxt = onehot(S_EBUSY);
        else if (cmd.blank)     nxt = cfg_async ? onehot(S_EBUSY) : state;
        else if (cmd.susp || cmd.resume) nxt = state;
        else                    nxt = onehot(S_ERROR);
      end
    end else if (state[S_QUERY] || state[S_ERROR]) begin
      if (wr && cmd.reset) nxt = onehot(S_READ);
    end else if (state[S_PBUSY]) begin
      if (op_done)               nxt = onehot(S_READ);
      else if (wr && cmd.susp)   nxt = onehot(S_PSUSP);
    end else if (state[S_PSUSP]) begin
      if (wr && cmd.resume)      nxt = onehot(S_PBUSY);
    end else if (state[S_EBUSY]) begin
      if (op_done)               nxt = onehot(S_READ);
      else if (wr && cmd.susp)   nxt = onehot(S_ESUSP);
    end else if (state[S_ESUSP]) begin
      if (wr && cmd.resume)      nxt = onehot(S_EBUSY);
    end else begin
      nxt = onehot(S_READ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= onehot(S_READ);
    else        state <= nxt;
  end

  AST_ONE_HOT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1); // R1
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state[S_ERROR] && !(wr && cmd.reset) |=> state[S_ERROR]); // R4
  AST_RESET_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.reset && state[S_PBUSY] && !op_done |=> state[S_PBUSY]); // R5
  AST_BLANK_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.blank && !cfg_async && state[S_READ] |=> state[S_READ]); // R7
  AST_SUSPEND_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.susp && state[S_PBUSY] && !op_done |=> state[S_PSUSP]); // R8
  AST_SUSPEND_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.susp && state[S_EBUSY] && !op_done |=> state[S_ESUSP]); // R8
  AST_RESUME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cmd.resume && (state[S_READ] || state[S_QUERY] || state[S_ERROR])
    |=> $stable(state)); // R9
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && (state[S_PBUSY] || state[S_EBUSY]) |=> state[S_READ]); // R10

endmodule

// File: rtl/fcmd_ctrl.sv
`timescale 1ns/1ps
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int               OFS_W     = 8,
  parameter logic [OFS_W-1:0] QUERY_OFS = 'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [15:0]      wr_data,
  input  logic             cfg_async,
  input  logic             op_done,
  output logic [N_ST-1:0]  mode,
  output logic             read_source
);

  cmd_t cmd;

  fcmd_decode #(.OFS_W(OFS_W), .QUERY_OFS(QUERY_OFS)) u_dec (
    .ofs  (wr_ofs),
    .data (wr_data),
    .cmd  (cmd)
  );

  fcmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_en),
    .cmd       (cmd),
    .cfg_async (cfg_async),
    .op_done   (op_done),
    .state     (mode)
  );

  assign read_source = mode[S_QUERY];

  AST_QUERY_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_source) |-> $past(mode[S_READ])); // R2

endmodule

// File: tb/fcmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module fcmd_ctrl_tb_top;
  import fcmd_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_ofs = '0;
  logic [15:0] wr_data = '0;
  logic       cfg_async = 1'b0;
  logic       op_done = 1'b0;
  logic [6:0] mode;
  logic       read_source;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  fcmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .cfg_async(cfg_async), .op_done(op_done),
    .mode(mode), .read_source(read_source)
  );

  function automatic int model(int st, bit wr, logic [7:0] lo, bit hit, bit asy, bit done);
    case (st)
      0: begin
        if (!wr) return 0;
        if (lo == 8'hF0) return 0;
        if (lo == 8'h90 || lo == 8'h98) return hit ? 1 : 6;
        if (lo == 8'hA0) return 2;
        if (lo == 8'h80) return 4;
        if (lo == 8'h33) return asy ? 4 : 0;
        if (lo == 8'hB0 || lo == 8'h30) return 0;
        return 6;
      end
      1, 6: return (wr && lo == 8'hF0) ? 0 : st;
      2: return done ? 0 : ((wr && lo == 8'hB0) ? 3 : 2);
      3: return (wr && lo == 8'h30) ? 2 : 3;
      4: return done ? 0 : ((wr && lo == 8'hB0) ? 5 : 4);
      5: return (wr && lo == 8'h30) ? 4 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int st, logic [7:0] lo, bit hit);
    if (lo == 8'hF0) return "R5";
    if (lo == 8'h90 || lo == 8'h98) return (st != 0) ? "R3" : (hit ? "R2" : "R4");
    if (lo == 8'hA0 || lo == 8'h80) return (st == 0) ? "R6" : "R11";
    if (lo == 8'h33) return (st == 0) ? "R7" : "R11";
    if (lo == 8'hB0) return "R8";
    if (lo == 8'h30) return "R9";
    return (st == 0) ? "R4" : "R11";
  endfunction

  task automatic chk(int exp, string tag);
    logic [6:0] em;
    em = 7'(1 << exp);
    checks++;
    if (mode !== em || read_source !== (exp == 1)) begin
      fails++;
      $display("FAIL %s: mode=%b read_source=%b expected mode=%b read_source=%b",
               tag, mode, read_source, em, (exp == 1));
    end
  endtask

  task automatic wr(logic [7:0] lo, logic [7:0] ofs, logic [7:0] hi);
    @(negedge clk);
    wr_en = 1'b1; wr_ofs = ofs; wr_data = {hi, lo};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go_state(int st);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    case (st)
      1: wr(8'h90, 8'h55, 8'h00);
      2: wr(8'hA0, 8'h00, 8'h00);
      3: begin wr(8'hA0, 8'h00, 8'h00); wr(8'hB0, 8'h00, 8'h00); end
      4: wr(8'h80, 8'h00, 8'h00);
      5: begin wr(8'h80, 8'h00, 8'h00); wr(8'hB0, 8'h00, 8'h00); end
      6: wr(8'h00, 8'h00, 8'h00);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(0, "R1 reset state");

    for (int st = 0; st < 7; st++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 256; b++) begin
          for (int h = 0; h < 2; h++) begin
            cfg_async = a[0];
            go_state(st);
            wr(8'(b), h[0] ? 8'h55 : 8'h56, 8'(b) ^ 8'h5A);
            chk(model(st, 1'b1, 8'(b), h[0], a[0], 1'b0), tag_of(st, 8'(b), h[0]));
          end
        end
      end
    end

    for (int st = 0; st < 7; st++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] lo;
        lo = (k == 1) ? 8'hB0 : 8'h30;
        cfg_async = 1'b0;
        go_state(st);
        @(negedge clk);
        op_done = 1'b1;
        if (k != 0) begin
          wr_en = 1'b1; wr_ofs = 8'h00; wr_data = {8'hC3, lo};
        end
        @(negedge clk);
        op_done = 1'b0; wr_en = 1'b0;
        chk(model(st, k != 0, lo, 1'b0, 1'b0, 1'b1), "R10 done collision");
      end
    end

    go_state(0);
    wr(8'h98, 8'h55, 8'hFF);
    chk(1, "R2 query with high byte set");
    wr(8'hA0, 8'h00, 8'h00);
    chk(1, "R11 program ignored in query");
    wr(8'hF0, 8'h00, 8'h12);
    chk(0, "R5 reset leaves query");

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule